// File: doc/BRIEF.md
# Trigger-Synchronized Up-Counter Timer

This block is an up-counting timer. An internal prescaler divides the system clock, and the counter climbs from 0 to an auto-reload limit before it wraps. Software writes the auto-reload and compare values into shadow registers. These only reach the active copies on an update event. Each compare channel drives a hit output for as long as the counter equals its active value.

A slave controller watches one raw trigger pin. The pin first goes through a two-stage synchronizer and then an edge detector whose direction software selects. When the slave controller is in reset mode and the pin is chosen as the trigger source, a qualified edge zeroes the counter and the prescaler, and counting restarts from 0. The same edge sets a sticky trigger flag and can raise an interrupt or a one-cycle DMA request. If the update-source bit is clear, the edge also produces an update event.

Software controls everything through a single-cycle write port. Flags are cleared by writing zeros to them.

Top module: `trig_sync_timer`

## Requirements
- R1: A trigger event clears both the counter and the prescaler divider, whether or not the counter is running. After the clear, the first count step comes a full prescale period (PSC+1 cycles) later.
- R2: A raw trigger level change seen at clock edge N produces the counter clear and the trigger flag at edge N+3. Up to edge N+2 the counter keeps counting normally.
- R3: Control bit 1 is the update-source bit. When it is 0, a trigger event is also an update event: the shadow auto-reload and compare values move to the active registers, and the update flag is set. When it is 1, the trigger leaves the active registers and the update flag untouched.
- R4: A trigger event sets the trigger flag. Writing the flags register (address 3) with bit 0 equal to 0 clears it, and a 1 in that bit leaves it as it is. When a set and a clear land in the same cycle, the flag ends up set.
- R5: The irq output is high when the trigger flag is set and control bit 12 (trigger interrupt enable) is 1, or when the update flag is set and control bit 14 (update interrupt enable) is 1. dma_req pulses for one cycle, together with the flag setting, on a trigger event only when control bit 13 is 1.
- R6: Control bit 2 selects the trigger edge. 0 accepts only rising edges of trig_raw, and 1 accepts only falling edges.
- R7: Trigger events happen only when control bits [6:4] equal 3'b100 (reset mode) and control bits [10:8] equal 3'b101 (trigger pin selected). Any other value in either field makes edges on trig_raw have no effect.
- R8: With prescale value P (address 1) and active auto-reload A, the counter advances once every P+1 cycles while running. It goes from A to 0, so k cycles after a forced update and a start it reads floor(k/(P+1)) mod (A+1).
- R9: Control bit 0 runs the counter. While it is 0, the counter holds its value unless a trigger event or a forced update occurs.
- R10: Writing bit 0 = 1 to address 4 forces an update: the counter and the prescaler clear and the shadow values load. A counter wrap from A to 0 also loads the shadows and sets the update flag, whatever the update-source bit says.
- R11: Compare channel i (shadow at address 5+i) drives cc_hit[i] high exactly in the cycles where the counter equals that channel's active compare value.
- R12: After reset the counter, both flags, irq, dma_req and cc_hit are 0, the shadow and active auto-reload and compare values are all ones, and the control and prescale registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0 control, 1 prescale, 2 auto-reload, 3 flags, 4 event, 5+i compare i |
| wr_data | input | 16 | Write data |
| trig_raw | input | 1 | Asynchronous trigger pin |
| cnt_val | output | 16 | Current counter value |
| trig_flag | output | 1 | Sticky trigger flag |
| upd_flag | output | 1 | Sticky update flag |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | One-cycle DMA request on trigger |
| cc_hit | output | 2 | Compare match per channel |

## Verification
The trigger flag can be set by a synchronized edge and cleared by a software write in the same clock cycle. To provoke this, the bench raises trig_raw and then times a flags write so that it is captured at exactly the third edge after the pin is first sampled, which is the edge where the event lands. The result is judged at the ports: the flag must read 1 after that edge and 0 only after a later clear write. The bench also places a trigger reset partway through a prescale period to show that the divider restarts along with the counter.

// File: rtl/tst_pkg.sv
package tst_pkg;

  // register data width shared by the write port
  localparam int REG_W = 16;

  // register addresses
  localparam int ADDR_CTRL  = 0;
  localparam int ADDR_PSC   = 1;
  localparam int ADDR_ARR   = 2;
  localparam int ADDR_FLAGS = 3;
  localparam int ADDR_EVGEN = 4;
  localparam int ADDR_CCR0  = 5;

  // slave controller encodings
  localparam logic [2:0] SLV_RESET = 3'b100;
  localparam logic [2:0] TSEL_PIN  = 3'b101;

  typedef struct packed {
    logic       uie;
    logic       tde;
    logic       tie;
    logic [2:0] tsel;
    logic [2:0] mode;
    logic       pol;
    logic       urs;
    logic       run;
  } ctrl_t;

endpackage

// File: rtl/tst_trig_front.sv
module tst_trig_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic trig_raw,
  input  logic pol,
  input  logic armed,
  output logic trig_evt
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;
  logic                   level;
  logic                   edge_hit;

  assign level = sync_q[SYNC_STAGES-1];

  // pol = 0 accepts rising edges, pol = 1 accepts falling edges
  always_comb begin
    if (pol) edge_hit = last_q & ~level;
    else     edge_hit = level & ~last_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q   <= '0;
      last_q   <= 1'b0;
      trig_evt <= 1'b0;
    end else begin
      sync_q[0] <= trig_raw;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
      last_q   <= level;
      trig_evt <= armed & edge_hit;
    end
  end

endmodule

// File: rtl/tst_regs.sv
module tst_regs
  import tst_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 16,
  parameter int NUM_CC = 2,
  parameter int ADDR_W = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [REG_W-1:0]              wr_data,
  input  logic                          trig_evt,
  input  logic                          ovf,
  output ctrl_t                         ctrl_q,
  output logic [PSC_W-1:0]              psc_q,
  output logic [CNT_W-1:0]              arr_pre,
  output logic [NUM_CC-1:0][CNT_W-1:0]  ccr_pre,
  output logic                          sw_ug,
  output logic                          trig_flag,
  output logic                          upd_flag,
  output logic                          irq,
  output logic                          dma_req
);

  localparam int NUM_REGS = ADDR_CCR0 + NUM_CC;

  logic [NUM_REGS-1:0] sel;
  logic                clr_t;
  logic                clr_u;
  logic                tflag_d;
  logic                uflag_d;
  ctrl_t               ctrl_d;

  always_comb begin
    for (int i = 0; i < NUM_REGS; i++) sel[i] = wr_en && (wr_addr == ADDR_W'(i));
  end

  always_comb begin
    ctrl_d      = '0;
    ctrl_d.run  = wr_data[0];
    ctrl_d.urs  = wr_data[1];
    ctrl_d.pol  = wr_data[2];
    ctrl_d.mode = wr_data[6:4];
    ctrl_d.tsel = wr_data[10:8];
    ctrl_d.tie  = wr_data[12];
    ctrl_d.tde  = wr_data[13];
    ctrl_d.uie  = wr_data[14];
  end

  assign sw_ug = sel[ADDR_EVGEN] && wr_data[0];
  assign clr_t = sel[ADDR_FLAGS] && !wr_data[0];
  assign clr_u = sel[ADDR_FLAGS] && !wr_data[1];

  // a set in the same cycle as a clear wins
  assign tflag_d = trig_evt | (trig_flag & ~clr_t);
  assign uflag_d = ovf | ((trig_evt | sw_ug) & ~ctrl_q.urs) | (upd_flag & ~clr_u);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      psc_q     <= '0;
      arr_pre   <= '1;
      ccr_pre   <= '1;
      trig_flag <= 1'b0;
      upd_flag  <= 1'b0;
      irq       <= 1'b0;
      dma_req   <= 1'b0;
    end else begin
      if (sel[ADDR_CTRL]) ctrl_q  <= ctrl_d;
      if (sel[ADDR_PSC])  psc_q   <= wr_data[PSC_W-1:0];
      if (sel[ADDR_ARR])  arr_pre <= wr_data[CNT_W-1:0];
      for (int i = 0; i < NUM_CC; i++) begin
        if (sel[ADDR_CCR0+i]) ccr_pre[i] <= wr_data[CNT_W-1:0];
      end
      trig_flag <= tflag_d;
      upd_flag  <= uflag_d;
      irq       <= (tflag_d & ctrl_q.tie) | (uflag_d & ctrl_q.uie);
      dma_req   <= trig_evt & ctrl_q.tde;
    end
  end

endmodule

// File: rtl/tst_time_base.sv
module tst_time_base #(
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 16,
  parameter int NUM_CC = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         run,
  input  logic [PSC_W-1:0]             psc_lim,
  input  logic [CNT_W-1:0]             arr_pre,
  input  logic [NUM_CC-1:0][CNT_W-1:0] ccr_pre,
  input  logic                         restart,
  input  logic                         load_req,
  output logic [CNT_W-1:0]             cnt_q,
  output logic                         ovf,
  output logic [NUM_CC-1:0]            cc_hit
);

  logic [PSC_W-1:0]              psc_cnt;
  logic [PSC_W-1:0]              psc_d;
  logic [CNT_W-1:0]              cnt_d;
  logic [CNT_W-1:0]              arr_act;
  logic [CNT_W-1:0]              arr_d;
  logic [NUM_CC-1:0][CNT_W-1:0]  ccr_act;
  logic [NUM_CC-1:0][CNT_W-1:0]  ccr_d;
  logic [NUM_CC-1:0]             hit_d;
  logic                          tick;
  logic                          wrap;
  logic                          load;

  always_comb begin
    tick = run && (psc_cnt == psc_lim);
    wrap = tick && (cnt_q == arr_act);
    ovf  = wrap && !restart;
    load = ovf || load_req;

    if (restart)   psc_d = '0;
    else if (tick) psc_d = '0;
    else if (run)  psc_d = psc_cnt + 1'b1;
    else           psc_d = psc_cnt;

    if (restart)   cnt_d = '0;
    else if (wrap) cnt_d = '0;
    else if (tick) cnt_d = cnt_q + 1'b1;
    else           cnt_d = cnt_q;

    arr_d = load ? arr_pre : arr_act;
  end

  // hit is judged against next-state values so it lines up with cnt_q
  for (genvar g = 0; g < NUM_CC; g++) begin : g_cc
    assign ccr_d[g] = load ? ccr_pre[g] : ccr_act[g];
    assign hit_d[g] = (cnt_d == ccr_d[g]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      psc_cnt <= '0;
      cnt_q   <= '0;
      arr_act <= '1;
      ccr_act <= '1;
      cc_hit  <= '0;
    end else begin
      psc_cnt <= psc_d;
      cnt_q   <= cnt_d;
      arr_act <= arr_d;
      ccr_act <= ccr_d;
      cc_hit  <= hit_d;
    end
  end

endmodule

// File: rtl/trig_sync_timer.sv
module trig_sync_timer
  import tst_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PSC_W       = 16,
  parameter int NUM_CC      = 2,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = $clog2(ADDR_CCR0 + NUM_CC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [REG_W-1:0]   wr_data,
  input  logic               trig_raw,
  output logic [CNT_W-1:0]   cnt_val,
  output logic               trig_flag,
  output logic               upd_flag,
  output logic               irq,
  output logic               dma_req,
  output logic [NUM_CC-1:0]  cc_hit
);

  ctrl_t                        ctrl_q;
  logic [PSC_W-1:0]             psc_q;
  logic [CNT_W-1:0]             arr_pre;
  logic [NUM_CC-1:0][CNT_W-1:0] ccr_pre;
  logic                         sw_ug;
  logic                         trig_evt;
  logic                         ovf;
  logic                         armed;
  logic                         run_w;
  logic                         restart;
  logic                         load_req;

  assign armed    = (ctrl_q.mode == SLV_RESET) && (ctrl_q.tsel == TSEL_PIN);
  assign run_w    = ctrl_q.run;
  assign restart  = trig_evt | sw_ug;
  assign load_req = (trig_evt & ~ctrl_q.urs) | sw_ug;

  tst_trig_front #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_front (
    .clk      (clk),
    .rst      (rst),
    .trig_raw (trig_raw),
    .pol      (ctrl_q.pol),
    .armed    (armed),
    .trig_evt (trig_evt)
  );

  tst_regs #(
    .CNT_W  (CNT_W),
    .PSC_W  (PSC_W),
    .NUM_CC (NUM_CC),
    .ADDR_W (ADDR_W)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .trig_evt  (trig_evt),
    .ovf       (ovf),
    .ctrl_q    (ctrl_q),
    .psc_q     (psc_q),
    .arr_pre   (arr_pre),
    .ccr_pre   (ccr_pre),
    .sw_ug     (sw_ug),
    .trig_flag (trig_flag),
    .upd_flag  (upd_flag),
    .irq       (irq),
    .dma_req   (dma_req)
  );

  tst_time_base #(
    .CNT_W  (CNT_W),
    .PSC_W  (PSC_W),
    .NUM_CC (NUM_CC)
  ) u_tb (
    .clk      (clk),
    .rst      (rst),
    .run      (run_w),
    .psc_lim  (psc_q),
    .arr_pre  (arr_pre),
    .ccr_pre  (ccr_pre),
    .restart  (restart),
    .load_req (load_req),
    .cnt_q    (cnt_val),
    .ovf      (ovf),
    .cc_hit   (cc_hit)
  );

endmodule

// File: rtl/tst_checker.sv
module tst_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             flags_clr,
  input logic             trig_evt,
  input logic             sw_ug,
  input logic             run,
  input logic [CNT_W-1:0] cnt_val,
  input logic             trig_flag,
  input logic             upd_flag,
  input logic             irq,
  input logic             dma_req
);

  AST_TRIG_CLEARS: assert property (@(posedge clk) disable iff (rst)
    trig_evt |=> (cnt_val == '0));  // R1

  AST_TRIG_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
    trig_evt |=> trig_flag);  // R4

  AST_FLAG_CLEARED_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
    $fell(trig_flag) |-> $past(flags_clr));  // R4

  AST_DMA_WITH_FLAG: assert property (@(posedge clk) disable iff (rst)
    dma_req |-> trig_flag);  // R5

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    irq |-> (trig_flag || upd_flag));  // R5

  AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (rst)
    (!run && !trig_evt && !sw_ug) |=> $stable(cnt_val));  // R9

  AST_FORCED_UPDATE_ZERO: assert property (@(posedge clk) disable iff (rst)
    sw_ug |=> (cnt_val == '0));  // R10

endmodule

bind trig_sync_timer tst_checker #(
  .CNT_W(CNT_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .flags_clr (wr_en && (wr_addr == ADDR_W'(tst_pkg::ADDR_FLAGS)) && !wr_data[0]),
  .trig_evt  (trig_evt),
  .sw_ug     (sw_ug),
  .run       (run_w),
  .cnt_val   (cnt_val),
  .trig_flag (trig_flag),
  .upd_flag  (upd_flag),
  .irq       (irq),
  .dma_req   (dma_req)
);

// File: tb/trig_sync_timer_tb.sv
module trig_sync_timer_tb;

  localparam int CLK_P = 10;
  localparam int NV    = 6;
  // {prescale, auto-reload, cycles}
  localparam logic [47:0] VEC [NV] = '{
    {16'd0, 16'h36, 16'd58},
    {16'd0, 16'd5,  16'd6},
    {16'd1, 16'd4,  16'd7},
    {16'd2, 16'd3,  16'd12},
    {16'd3, 16'd9,  16'd25},
    {16'd0, 16'h36, 16'h36}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        trig_raw = 1'b0;
  logic [15:0] cnt_val;
  logic        trig_flag;
  logic        upd_flag;
  logic        irq;
  logic        dma_req;
  logic [1:0]  cc_hit;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  trig_sync_timer u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .trig_raw(trig_raw), .cnt_val(cnt_val), .trig_flag(trig_flag),
    .upd_flag(upd_flag), .irq(irq), .dma_req(dma_req), .cc_hit(cc_hit)
  );

  function automatic logic [15:0] mk(input logic run, input logic urs, input logic pol,
                                     input logic [2:0] mode, input logic [2:0] tsel,
                                     input logic tie, input logic tde, input logic uie);
    logic [15:0] v;
    v = '0;
    v[0] = run; v[1] = urs; v[2] = pol; v[6:4] = mode; v[10:8] = tsel;
    v[12] = tie; v[13] = tde; v[14] = uie;
    return v;
  endfunction

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [15:0] c_main;
    step(3);
    rst = 1'b0;
    step(1);
    // R12 reset state
    chk("R12 cnt", cnt_val, 0);
    chk("R12 trig_flag", trig_flag, 0);
    chk("R12 upd_flag", upd_flag, 0);
    chk("R12 irq", irq, 0);
    chk("R12 dma", dma_req, 0);
    chk("R12 cc_hit", cc_hit, 0);

    // R8 table walk
    for (int i = 0; i < NV; i++) begin
      int p, a, k;
      p = int'(VEC[i][47:32]); a = int'(VEC[i][31:16]); k = int'(VEC[i][15:0]);
      wr(3'd0, 16'h0);
      wr(3'd1, 16'(p));
      wr(3'd2, 16'(a));
      wr(3'd4, 16'h1);
      wr(3'd0, mk(1, 0, 0, 3'b000, 3'b000, 0, 0, 0));
      step(k);
      chk("R8 count", cnt_val, (k / (p + 1)) % (a + 1));
    end

    // R1 R2 R3 R4 R5: trigger reset with update
    wr(3'd0, 16'h0);
    wr(3'd1, 16'h0);
    wr(3'd2, 16'h36);
    wr(3'd4, 16'h1);
    wr(3'd3, 16'h0);
    c_main = mk(1, 0, 0, 3'b100, 3'b101, 1, 1, 0);
    wr(3'd0, c_main);
    wr(3'd2, 16'd3);
    step(9);
    chk("R8 pre-trigger", cnt_val, 10);
    trig_raw = 1'b1;
    step(3);
    chk("R2 still counting", cnt_val, 13);
    chk("R2 flag not yet", trig_flag, 0);
    step(1);
    chk("R1 cleared", cnt_val, 0);
    chk("R4 flag set", trig_flag, 1);
    chk("R3 update flag", upd_flag, 1);
    chk("R5 irq", irq, 1);
    chk("R5 dma pulse", dma_req, 1);
    step(1);
    chk("R1 restart", cnt_val, 1);
    chk("R5 dma one cycle", dma_req, 0);
    step(3);
    chk("R3 reload loaded", cnt_val, 0);

    // R6 polarity
    wr(3'd3, 16'h0);
    trig_raw = 1'b0;
    step(6);
    chk("R6 falling ignored", trig_flag, 0);
    wr(3'd0, c_main | 16'h4);
    trig_raw = 1'b1;
    step(6);
    chk("R6 rising ignored", trig_flag, 0);
    trig_raw = 1'b0;
    step(4);
    chk("R6 falling accepted", trig_flag, 1);

    // R4 set and clear in the same cycle
    wr(3'd3, 16'h0);
    wr(3'd0, c_main);
    trig_raw = 1'b1;
    step(3);
    wr(3'd3, 16'h0);
    chk("R4 set wins", trig_flag, 1);
    wr(3'd3, 16'h1);
    chk("R4 one keeps", trig_flag, 1);
    wr(3'd3, 16'h0);
    chk("R4 cleared", trig_flag, 0);

    // R3 with update-source bit set
    wr(3'd0, 16'h0);
    wr(3'd2, 16'h36);
    wr(3'd4, 16'h1);
    wr(3'd3, 16'h0);
    wr(3'd2, 16'd3);
    trig_raw = 1'b0;
    step(4);
    wr(3'd0, mk(1, 1, 0, 3'b100, 3'b101, 1, 1, 0));
    step(5);
    trig_raw = 1'b1;
    step(4);
    chk("R3 urs cleared", cnt_val, 0);
    chk("R3 urs trig flag", trig_flag, 1);
    chk("R3 urs no update flag", upd_flag, 0);
    step(4);
    chk("R3 urs no reload", cnt_val, 4);

    // R7 wrong select, then wrong mode
    wr(3'd3, 16'h0);
    trig_raw = 1'b0;
    step(4);
    wr(3'd2, 16'h36);
    wr(3'd0, mk(1, 0, 0, 3'b100, 3'b001, 1, 1, 0));
    wr(3'd4, 16'h1);
    step(5);
    trig_raw = 1'b1;
    step(5);
    chk("R7 select cnt", cnt_val, 10);
    chk("R7 select flag", trig_flag, 0);
    trig_raw = 1'b0;
    step(4);
    wr(3'd0, mk(1, 0, 0, 3'b000, 3'b101, 1, 1, 0));
    wr(3'd4, 16'h1);
    step(5);
    trig_raw = 1'b1;
    step(5);
    chk("R7 mode cnt", cnt_val, 10);
    chk("R7 mode flag", trig_flag, 0);

    // R5 enables off
    wr(3'd3, 16'h0);
    trig_raw = 1'b0;
    step(4);
    wr(3'd0, mk(1, 0, 0, 3'b100, 3'b101, 0, 0, 0));
    trig_raw = 1'b1;
    step(4);
    chk("R5 flag", trig_flag, 1);
    chk("R5 irq gated", irq, 0);
    chk("R5 dma gated", dma_req, 0);

    // R9 stopped counter, R1 trigger while stopped
    wr(3'd0, mk(0, 0, 0, 3'b100, 3'b101, 0, 0, 0));
    step(5);
    chk("R9 held", cnt_val, 1);
    trig_raw = 1'b0;
    step(4);
    trig_raw = 1'b1;
    step(4);
    chk("R1 clear while stopped", cnt_val, 0);

    // R1 prescaler cleared by trigger
    wr(3'd0, 16'h0);
    wr(3'd1, 16'd3);
    wr(3'd2, 16'h36);
    wr(3'd4, 16'h1);
    wr(3'd3, 16'h0);
    trig_raw = 1'b0;
    step(4);
    wr(3'd0, mk(1, 0, 0, 3'b100, 3'b101, 0, 0, 0));
    step(6);
    chk("R8 prescaled", cnt_val, 1);
    trig_raw = 1'b1;
    step(4);
    chk("R1 psc trig clear", cnt_val, 0);
    step(3);
    chk("R1 prescaler restarted", cnt_val, 0);
    step(1);
    chk("R1 first step", cnt_val, 1);

    // R10 R11 compare and overflow update
    wr(3'd0, 16'h0);
    wr(3'd1, 16'h0);
    wr(3'd2, 16'd4);
    wr(3'd5, 16'd2);
    wr(3'd6, 16'd4);
    wr(3'd4, 16'h1);
    wr(3'd3, 16'h0);
    wr(3'd0, mk(1, 1, 0, 3'b000, 3'b000, 0, 0, 0));
    chk("R11 no hit", cc_hit, 0);
    step(2);
    chk("R11 hit ch0", cc_hit, 2'b01);
    step(2);
    chk("R11 hit ch1", cc_hit, 2'b10);
    chk("R10 no update yet", upd_flag, 0);
    step(1);
    chk("R10 wrap", cnt_val, 0);
    chk("R10 update flag", upd_flag, 1);
    chk("R11 hit off", cc_hit, 2'b00);

    finish_run();
  end

endmodule